// File: doc/BRIEF.md
# Wakeup Edge Interrupt Flag Register

This block watches eight external wakeup pins and records a falling edge on each of them in a flag register. A per-pin mode select decides whether a pin counts as a wakeup source at all. Pins outside wakeup mode are ignored. Every pin level is brought into the clock domain through a two-stage synchronizer before the edge detector sees it.

Software reads the eight flags at a single register location and clears them by writing zeros. A one written to a bit leaves that flag alone. Taking the interrupt does not clear anything: a flag stays set until software clears it. The flags are combined into one interrupt request. That request is gated by a shared wakeup enable and by a global mask, and it is registered before it leaves the block.

Top module: `wake_flag_reg`

## Requirements
- R1: After reset every flag reads 0 and `irq_o` is 0.
- R2: If pin n is sampled high at one rising edge and low at the next, and `mode_sel_i[n]` is 1, flag n (bit n of `rd_data_o`) becomes 1 at the second rising edge after the first low sample.
- R3: When `mode_sel_i[n]` is 0 at the edge where flag n would be set, that edge sets no flag. A mode bit of 1 means the pin is a wakeup input.
- R4: When `wr_en_i` is 1 and bit n of `wr_data_i` is 0, flag n is cleared at that edge. A 1 in bit n leaves flag n unchanged.
- R5: If a set and a clear of the same flag fall on the same edge, the flag ends up 1.
- R6: Flags stay set while the request is raised; only a write clears them.
- R7: With `irq_en_i` at 0, `irq_o` is 0 after the next edge, and flags still record edges.
- R8: With `glb_mask_i` at 1, `irq_o` is 0 after the next edge, whatever the flags and the enable are.
- R9: `irq_o` after a rising edge equals (OR of the flags before that edge) AND `irq_en_i` AND NOT `glb_mask_i`, as sampled at that edge.
- R10: Reads have no side effect, and a rising pin edge (low to high) sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous wakeup pin levels |
| mode_sel_i | input | 8 | Per-pin wakeup mode select, 1 = wakeup input |
| irq_en_i | input | 1 | Shared wakeup interrupt enable |
| glb_mask_i | input | 1 | Global interrupt mask, 1 = suppress |
| wr_en_i | input | 1 | Write strobe for the flag register |
| wr_data_i | input | 8 | Write data; 0 bits clear flags |
| rd_data_o | output | 8 | Current flag values |
| irq_o | output | 1 | Registered wakeup interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands on exactly the edge where a synchronized falling edge sets the same flag. To hit it, the stimulus counts the synchronizer latency. It first drives the pin high for several cycles, then drives it low. Two edges later it issues a zero write, and it checks that the flag survives. Random pin, mode, enable, mask and write traffic then covers the other interleavings against a cycle model in the bench.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int WAKE_PINS_DEF  = 8;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef struct packed {
        logic irq;
    } req_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int NUM_PINS   = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] fall_o
);
    localparam int LAST = SYNC_DEPTH - 1;

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] chain;
        logic                  prev;
    } sync_state_t;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        sync_state_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[SYNC_DEPTH-2:0], pin_i[g]};
            st_d.prev  = st_q.chain[LAST];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign fall_o[g] = st_q.prev & ~st_q.chain[LAST];
    end
endmodule

// File: rtl/wake_flag_store.sv
module wake_flag_store #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic [NUM_PINS-1:0] mode_sel_i,
    input  logic                wr_en_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    output logic [NUM_PINS-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [NUM_PINS-1:0] clr_d;
    logic [NUM_PINS-1:0] set_d;

    always_comb begin
        clr_d    = wr_en_i ? ~wr_data_i : '0;
        set_d    = fall_i & mode_sel_i;
        st_d     = st_q;
        // a set on the same edge as a clear wins
        st_d.flags = (st_q.flags & ~clr_d) | set_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/wake_req_gen.sv
module wake_req_gen
    import wake_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] flags_i,
    input  logic                irq_en_i,
    input  logic                glb_mask_i,
    output logic                irq_o
);
    req_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = (|flags_i) & irq_en_i & ~glb_mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg
    import wake_pkg::*;
#(
    parameter int NUM_PINS   = WAKE_PINS_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] mode_sel_i,
    input  logic                irq_en_i,
    input  logic                glb_mask_i,
    input  logic                wr_en_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    output logic [NUM_PINS-1:0] rd_data_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] fall;
    logic [NUM_PINS-1:0] flags;

    wake_sync #(.NUM_PINS(NUM_PINS), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .fall_o(fall)
    );

    wake_flag_store #(.NUM_PINS(NUM_PINS)) u_store (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .mode_sel_i(mode_sel_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flags_o(flags)
    );

    wake_req_gen #(.NUM_PINS(NUM_PINS)) u_req (
        .clk(clk), .rst_n(rst_n), .flags_i(flags), .irq_en_i(irq_en_i),
        .glb_mask_i(glb_mask_i), .irq_o(irq_o)
    );

    assign rd_data_o = flags;
endmodule

// File: rtl/wake_flag_reg_chk.sv
module wake_flag_reg_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] mode_sel_i,
    input logic                irq_en_i,
    input logic                glb_mask_i,
    input logic                wr_en_i,
    input logic [NUM_PINS-1:0] wr_data_i,
    input logic [NUM_PINS-1:0] rd_data_o,
    input logic                irq_o
);
    // R8
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glb_mask_i |=> !irq_o);

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !irq_o);

    // R9
    req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rd_data_o) && irq_en_i && !glb_mask_i) |=> irq_o);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (&wr_data_i)) |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

    // R3
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data_o & ~$past(rd_data_o) & ~$past(mode_sel_i)) == '0));
endmodule

bind wake_flag_reg wake_flag_reg_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i), .irq_en_i(irq_en_i),
    .glb_mask_i(glb_mask_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
);

// File: tb/sim_wake_flag_reg.sv
`timescale 1ns/1ps
module sim_wake_flag_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0, mode_sel_i = '0, wr_data_i = '1;
    logic       irq_en_i = 1'b0, glb_mask_i = 1'b0, wr_en_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] h1 = '0, h2 = '0, h3 = '0, ef = '0;
    logic       eirq = 1'b0;
    string      tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_flag_reg u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_sel_i(mode_sel_i),
        .irq_en_i(irq_en_i), .glb_mask_i(glb_mask_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] p3,
            input logic [7:0] p2, input logic [7:0] md, input logic we, input logic [7:0] wd);
        logic [7:0] clr = we ? ~wd : 8'h00;
        return (f & ~clr) | (p3 & ~p2 & md);
    endfunction

    function automatic logic next_irq(input logic [7:0] f, input logic en, input logic mk);
        return (|f) & en & ~mk;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            h1 = '0; h2 = '0; h3 = '0; ef = '0; eirq = 1'b0;
        end else begin
            eirq = next_irq(ef, irq_en_i, glb_mask_i);
            ef   = next_flags(ef, h3, h2, mode_sel_i, wr_en_i, wr_data_i);
            h3 = h2; h2 = h1; h1 = pin_i;
        end
        @(negedge clk);
        check8({tag, " flags"}, rd_data_o, ef);
        check8({tag, " irq"}, {7'd0, irq_o}, {7'd0, eirq});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        rst_n = 1'b1;
        tag = "R1";
        tick();
        check8("R1 reset flags", rd_data_o, 8'h00);

        // R2: falling edge on pin 0 in wakeup mode
        tag = "R2"; mode_sel_i = 8'hFF; irq_en_i = 1'b1;
        pin_i = 8'h01; repeat (3) tick();
        pin_i = 8'h00; tick(); tick();
        check8("R2 before set", rd_data_o, 8'h00);
        tick();
        check8("R2 set", rd_data_o, 8'h01);
        tick();
        check8("R9 irq", {7'd0, irq_o}, 8'h01);

        // R6: flag persists while request is high
        tag = "R6"; repeat (5) tick();
        check8("R6 persist", rd_data_o, 8'h01);

        // R4: writing ones keeps, writing zero clears
        tag = "R4"; wr_en_i = 1'b1; wr_data_i = 8'hFF; tick();
        check8("R4 write ones", rd_data_o, 8'h01);
        wr_data_i = 8'hFE; tick(); wr_en_i = 1'b0; wr_data_i = 8'hFF;
        check8("R4 write zero", rd_data_o, 8'h00);

        // R3: pin 1 not in wakeup mode
        tag = "R3"; mode_sel_i = 8'hFD;
        pin_i = 8'h02; repeat (3) tick(); pin_i = 8'h00; repeat (4) tick();
        check8("R3 mode off", rd_data_o, 8'h00);

        // R10: rising edge and idle reads leave flags alone
        tag = "R10"; mode_sel_i = 8'hFF; pin_i = 8'hF0; repeat (5) tick();
        check8("R10 rising", rd_data_o, 8'h00);

        // R5: clear on same edge as set
        tag = "R5"; pin_i = 8'h00; tick(); tick();
        wr_en_i = 1'b1; wr_data_i = 8'h00; tick(); wr_en_i = 1'b0; wr_data_i = 8'hFF;
        check8("R5 set wins", rd_data_o, 8'hF0);

        // R7 and R8: gated request, flags still record
        tag = "R7"; irq_en_i = 1'b0; tick(); tick();
        check8("R7 irq low", {7'd0, irq_o}, 8'h00);
        tag = "R8"; irq_en_i = 1'b1; glb_mask_i = 1'b1; tick(); tick();
        check8("R8 irq masked", {7'd0, irq_o}, 8'h00);
        glb_mask_i = 1'b0;

        // random mix, R2 R3 R4 R7 R8 R9 against the model
        tag = "R9 random";
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 3) == 0) pin_i = 8'($urandom);
            if ($urandom_range(0, 15) == 0) mode_sel_i = 8'($urandom) | 8'($urandom);
            irq_en_i   = ($urandom_range(0, 7) != 0);
            glb_mask_i = ($urandom_range(0, 7) == 0);
            wr_en_i    = ($urandom_range(0, 5) == 0);
            wr_data_i  = 8'($urandom) | 8'($urandom) | 8'($urandom);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule